// File: doc/BRIEF.md
# Unified Buffer Partition Allocator

This block splits one shared on-chip entry buffer into five regions that sit back to back from offset 0. The regions belong, in this order, to the vertex, geometry, clip, setup and constant stages. The vertex, geometry and clip regions all use the vertex entry size. The setup and constant regions each have their own entry size. When the stage entry sizes change, a recalculate strobe starts a search for the largest entry counts that still fit the buffer.

The search runs in tiers. In the two larger device modes it first tries a boosted tier. It then tries the preferred tier and last the minimum tier. A tier is checked with a sequential multiply-accumulate that walks the five regions one per cycle, followed by a single fit comparison.

A constrained flag records that the block had to fall below its best counts. While it is set, any change in entry size triggers a new search, so the block can climb back to larger counts once the sizes shrink. The outputs are the start offsets of the four regions after the vertex region (the vertex region always starts at 0), the constrained flag, a one-cycle fence-changed pulse and a fatal flag.

Top module: `ubuf_partition_alloc`

## Requirements
- R1: Regions are placed contiguously in the order vertex (start 0), geometry, clip, setup, constant. Each region's length is its count times its entry size. Vertex, geometry and clip use the vertex size, setup uses the setup size and constant uses the constant size.
- R2: In base mode (`mode_i` = 0 or 3) the first tier tried is the preferred one, with counts vertex 32, geometry 8, clip 10, setup 8, constant 4. If it fits, `constrained_o` is cleared.
- R3: In mode 1 the first tier is the preferred tier with vertex raised to 128 and setup raised to 48. If it fits, `constrained_o` is cleared.
- R4: In mode 2 the first tier is the preferred tier with vertex raised to 64. If it fits, `constrained_o` is cleared.
- R5: If a boosted tier does not fit, the preferred tier is tried next. If the preferred tier then fits, `constrained_o` is set.
- R6: If the preferred tier does not fit, the minimum tier is tried: vertex 16, geometry 4, clip 5, setup 1, constant 1. If it fits, `constrained_o` is set.
- R7: If the minimum tier does not fit, `fatal_o` and `constrained_o` go high, the region starts are left unchanged and no fence pulse is produced. `fatal_o` clears at the next successful recalculation.
- R8: Any entry size of 0 is treated as 1.
- R9: A strobe starts work only when some clamped size exceeds its stored value, or when `constrained_o` is high and some clamped size differs from its stored value. Any other strobe has no effect: `busy_o` stays low, no pulse is produced and the outputs are unchanged.
- R10: When `constrained_o` is high, a strobe with a smaller size still re-partitions the buffer.
- R11: `busy_o` is high for 6 cycles for each tier tried. A strobe that arrives while `busy_o` is high is ignored.
- R12: `fence_pulse_o` is high for exactly one cycle, in the cycle in which `busy_o` first reads low after a successful search. The region starts change only together with that pulse.
- R13: After reset all starts are 0 and `busy_o`, `constrained_o`, `fence_pulse_o` and `fatal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recalc_i | input | 1 | Recalculate strobe |
| mode_i | input | 2 | 0/3 base, 1 wide boost, 2 mid boost |
| vtx_size_i | input | SZW | Vertex entry size |
| setup_size_i | input | SZW | Setup entry size |
| const_size_i | input | SZW | Constant entry size |
| total_size_i | input | OFFW | Total buffer size |
| busy_o | output | 1 | Search in progress |
| geo_start_o | output | OFFW | Geometry region start |
| clip_start_o | output | OFFW | Clip region start |
| setup_start_o | output | OFFW | Setup region start |
| const_start_o | output | OFFW | Constant region start |
| constrained_o | output | 1 | Counts below the best tier |
| fence_pulse_o | output | 1 | One-cycle layout-changed pulse |
| fatal_o | output | 1 | Minimum tier did not fit |

## Verification
The allocator is driven through a sequence of size, total and mode sets, each chosen so that the search stops at a known tier. These cover a base layout that fits at once, boosted layouts in both larger modes, a boosted failure that lands on the preferred tier, a preferred failure that lands on the minimum tier, and a minimum failure that ends in fatal. The busy length tells apart how many tiers were tried, and the start offsets tell apart which counts were finally kept. Further cases check the triggering rule: a repeated strobe with equal sizes must do nothing, a smaller size while constrained must re-partition, and all-zero sizes must give the same layout as all-one sizes. A strobe injected during a search must not alter that search's result.

// File: rtl/ubuf_part_pkg.sv
// Package: shared types and tier count tables for the buffer partition allocator.
// Assumes five regions in the fixed order vertex, geometry, clip, setup, constant.
package ubuf_part_pkg;

    localparam int NREG      = 5;
    localparam int REG_SETUP = 3;
    localparam int REG_CONST = 4;

    typedef enum logic [1:0] {
        TIER_BOOST = 2'd0,
        TIER_PREF  = 2'd1,
        TIER_MIN   = 2'd2
    } tier_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_JUDGE = 2'd2
    } state_e;

    localparam logic [1:0] MODE_WIDE = 2'd1;
    localparam logic [1:0] MODE_MID  = 2'd2;

    // Entry count of region k for tier t under a device mode.
    function automatic int tier_count(tier_e t, logic [1:0] mode, int k);
        int pref;
        int res;
        case (k)
            0:       pref = 32;
            1:       pref = 8;
            2:       pref = 10;
            3:       pref = 8;
            default: pref = 4;
        endcase
        res = pref;
        case (t)
            TIER_MIN: begin
                case (k)
                    0:       res = 16;
                    1:       res = 4;
                    2:       res = 5;
                    default: res = 1;
                endcase
            end
            TIER_BOOST: begin
                if (k == 0 && mode == MODE_WIDE) res = 128;
                if (k == 0 && mode == MODE_MID)  res = 64;
                if (k == REG_SETUP && mode == MODE_WIDE) res = 48;
            end
            default: res = pref;
        endcase
        return res;
    endfunction

    // True when the mode has a boosted tier to try first.
    function automatic logic mode_boosted(logic [1:0] mode);
        return (mode == MODE_WIDE) || (mode == MODE_MID);
    endfunction

endpackage

// File: rtl/ubuf_size_gate.sv
// Size gate: clamps incoming entry sizes to at least 1, holds the sizes used
// by the last recalculation, and decides whether a strobe needs a new layout.
// Assumes load_i is raised only for a strobe that is accepted.
module ubuf_size_gate #(
    parameter int SZW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SZW-1:0] vtx_raw_i,
    input  logic [SZW-1:0] setup_raw_i,
    input  logic [SZW-1:0] const_raw_i,
    input  logic           load_i,
    input  logic           constrained_i,
    output logic [SZW-1:0] vtx_q_o,
    output logic [SZW-1:0] setup_q_o,
    output logic [SZW-1:0] const_q_o,
    output logic           need_o
);

    logic [SZW-1:0] vtx_c, setup_c, const_c;
    logic           grew, differs;

    // Clamp each size up to one.
    always_comb begin
        vtx_c   = (vtx_raw_i   == '0) ? SZW'(1) : vtx_raw_i;
        setup_c = (setup_raw_i == '0) ? SZW'(1) : setup_raw_i;
        const_c = (const_raw_i == '0) ? SZW'(1) : const_raw_i;
    end

    // Trigger rule: any growth, or any change while constrained.
    always_comb begin
        grew    = (vtx_c > vtx_q_o) || (setup_c > setup_q_o) || (const_c > const_q_o);
        differs = (vtx_c != vtx_q_o) || (setup_c != setup_q_o) || (const_c != const_q_o);
        need_o  = grew || (constrained_i && differs);
    end

    // Store the clamped sizes when a recalculation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtx_q_o   <= '0;
            setup_q_o <= '0;
            const_q_o <= '0;
        end else if (load_i) begin
            vtx_q_o   <= vtx_c;
            setup_q_o <= setup_c;
            const_q_o <= const_c;
        end
    end

endmodule

// File: rtl/ubuf_layout_mac.sv
// Layout accumulator: one count-times-size product per step. Before each step
// it captures the running sum as the start of the region being added.
// Assumes steps arrive with index 0..NREG-1 in order after a clear.
module ubuf_layout_mac #(
    parameter int CNTW = 8,
    parameter int SZW  = 6,
    parameter int ACCW = 17,
    parameter int OFFW = 12,
    parameter int NREG = 5,
    parameter int IDXW = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       step_i,
    input  logic [IDXW-1:0]            idx_i,
    input  logic [CNTW-1:0]            cnt_i,
    input  logic [SZW-1:0]             size_i,
    output logic [ACCW-1:0]            acc_o,
    output logic [NREG-1:1][OFFW-1:0]  starts_o
);

    logic [ACCW-1:0] prod;

    // Product of the current region's count and entry size.
    always_comb prod = ACCW'(cnt_i) * ACCW'(size_i);

    // Running end-of-layout sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) acc_o <= '0;
        else if (step_i)     acc_o <= acc_o + prod;
    end

    // Per-region start capture, one register per region after the first.
    for (genvar g = 1; g < NREG; g++) begin : g_start
        always_ff @(posedge clk) begin
            if (!rst_n)
                starts_o[g] <= '0;
            else if (step_i && idx_i == IDXW'(g))
                starts_o[g] <= OFFW'(acc_o);
        end
    end

endmodule

// File: rtl/ubuf_partition_alloc.sv
// Top: tiered search for the region entry counts of a shared entry buffer.
// Tries boosted (larger modes only), then preferred, then minimum counts.
// Each tier takes NREG accumulate cycles and one judge cycle. Outputs update
// only when a search ends.
// Assumes total_size_i and mode_i are sampled with the accepted strobe.
module ubuf_partition_alloc #(
    parameter int SZW  = 6,
    parameter int OFFW = 12,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            recalc_i,
    input  logic [1:0]      mode_i,
    input  logic [SZW-1:0]  vtx_size_i,
    input  logic [SZW-1:0]  setup_size_i,
    input  logic [SZW-1:0]  const_size_i,
    input  logic [OFFW-1:0] total_size_i,
    output logic            busy_o,
    output logic [OFFW-1:0] geo_start_o,
    output logic [OFFW-1:0] clip_start_o,
    output logic [OFFW-1:0] setup_start_o,
    output logic [OFFW-1:0] const_start_o,
    output logic            constrained_o,
    output logic            fence_pulse_o,
    output logic            fatal_o
);
    import ubuf_part_pkg::*;

    localparam int IDXW = $clog2(NREG);
    localparam int ACCW = CNTW + SZW + 3;

    state_e          state_q;
    tier_e           tier_q;
    logic [IDXW-1:0] k_q;
    logic [1:0]      mode_q;
    logic [OFFW-1:0] tot_q;
    logic            work_cons_q;

    logic [SZW-1:0]  vtx_sz, setup_sz, const_sz, size_sel;
    logic [CNTW-1:0] cnt_sel;
    logic            need, accept, fits;
    logic [ACCW-1:0] acc;
    logic [NREG-1:1][OFFW-1:0] starts;

    assign accept = (state_q == ST_IDLE) && recalc_i && need;

    ubuf_size_gate #(.SZW(SZW)) gate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .vtx_raw_i     (vtx_size_i),
        .setup_raw_i   (setup_size_i),
        .const_raw_i   (const_size_i),
        .load_i        (accept),
        .constrained_i (constrained_o),
        .vtx_q_o       (vtx_sz),
        .setup_q_o     (setup_sz),
        .const_q_o     (const_sz),
        .need_o        (need)
    );

    // Pick the count and entry size of the region being accumulated.
    always_comb begin
        cnt_sel = CNTW'(tier_count(tier_q, mode_q, int'(k_q)));
        if (k_q == IDXW'(REG_CONST))      size_sel = const_sz;
        else if (k_q == IDXW'(REG_SETUP)) size_sel = setup_sz;
        else                              size_sel = vtx_sz;
    end

    ubuf_layout_mac #(
        .CNTW(CNTW), .SZW(SZW), .ACCW(ACCW), .OFFW(OFFW), .NREG(NREG), .IDXW(IDXW)
    ) mac_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q != ST_CALC),
        .step_i   (state_q == ST_CALC),
        .idx_i    (k_q),
        .cnt_i    (cnt_sel),
        .size_i   (size_sel),
        .acc_o    (acc),
        .starts_o (starts)
    );

    // Fit test: end of the constant region against the total size.
    always_comb fits = acc <= {{(ACCW-OFFW){1'b0}}, tot_q};

    assign busy_o = (state_q != ST_IDLE);

    // Search sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            tier_q        <= TIER_PREF;
            k_q           <= '0;
            mode_q        <= '0;
            tot_q         <= '0;
            work_cons_q   <= 1'b0;
            geo_start_o   <= '0;
            clip_start_o  <= '0;
            setup_start_o <= '0;
            const_start_o <= '0;
            constrained_o <= 1'b0;
            fence_pulse_o <= 1'b0;
            fatal_o       <= 1'b0;
        end else begin
            fence_pulse_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q      <= mode_i;
                        tot_q       <= total_size_i;
                        tier_q      <= mode_boosted(mode_i) ? TIER_BOOST : TIER_PREF;
                        work_cons_q <= 1'b0;
                        k_q         <= '0;
                        state_q     <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (k_q == IDXW'(NREG - 1)) begin
                        k_q     <= '0;
                        state_q <= ST_JUDGE;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                ST_JUDGE: begin
                    if (fits) begin
                        geo_start_o   <= starts[1];
                        clip_start_o  <= starts[2];
                        setup_start_o <= starts[3];
                        const_start_o <= starts[4];
                        constrained_o <= work_cons_q;
                        fatal_o       <= 1'b0;
                        fence_pulse_o <= 1'b1;
                        state_q       <= ST_IDLE;
                    end else if (tier_q == TIER_BOOST) begin
                        tier_q      <= TIER_PREF;
                        work_cons_q <= 1'b1;
                        state_q     <= ST_CALC;
                    end else if (tier_q == TIER_PREF) begin
                        tier_q      <= TIER_MIN;
                        work_cons_q <= 1'b1;
                        state_q     <= ST_CALC;
                    end else begin
                        fatal_o       <= 1'b1;
                        constrained_o <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ubuf_partition_alloc_chk.sv
// Checker: port-level temporal properties of the partition allocator.
// Assumes it is bound to ubuf_partition_alloc.
module ubuf_partition_alloc_chk #(
    parameter int OFFW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic [OFFW-1:0] geo_start_o,
    input logic [OFFW-1:0] clip_start_o,
    input logic [OFFW-1:0] setup_start_o,
    input logic [OFFW-1:0] const_start_o,
    input logic            constrained_o,
    input logic            fence_pulse_o,
    input logic            fatal_o
);

    // R12
    fence_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_pulse_o |=> !fence_pulse_o);

    // R12
    fence_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_pulse_o |-> (!busy_o && $past(busy_o)));

    // R12
    starts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fence_pulse_o |-> ($stable(geo_start_o) && $stable(clip_start_o) &&
                            $stable(setup_start_o) && $stable(const_start_o)));

    // R1
    region_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_start_o <= clip_start_o) && (clip_start_o <= setup_start_o) &&
        (setup_start_o <= const_start_o));

    // R7
    fatal_constrained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> constrained_o);

    // R7
    fatal_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> !fence_pulse_o);

    // R6
    constrained_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(constrained_o) |-> (fence_pulse_o || $rose(fatal_o)));

endmodule

bind ubuf_partition_alloc ubuf_partition_alloc_chk #(.OFFW(OFFW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .geo_start_o   (geo_start_o),
    .clip_start_o  (clip_start_o),
    .setup_start_o (setup_start_o),
    .const_start_o (const_start_o),
    .constrained_o (constrained_o),
    .fence_pulse_o (fence_pulse_o),
    .fatal_o       (fatal_o)
);

// File: tb/ubuf_partition_alloc_tb_top.sv
// Directed bench for the partition allocator: one task per scenario.
module ubuf_partition_alloc_tb_top;

    localparam int SZW  = 6;
    localparam int OFFW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            recalc_i = 1'b0;
    logic [1:0]      mode_i = '0;
    logic [SZW-1:0]  vtx_size_i = '0;
    logic [SZW-1:0]  setup_size_i = '0;
    logic [SZW-1:0]  const_size_i = '0;
    logic [OFFW-1:0] total_size_i = '0;
    logic            busy_o, constrained_o, fence_pulse_o, fatal_o;
    logic [OFFW-1:0] geo_start_o, clip_start_o, setup_start_o, const_start_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ubuf_partition_alloc #(.SZW(SZW), .OFFW(OFFW), .CNTW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .recalc_i(recalc_i), .mode_i(mode_i),
        .vtx_size_i(vtx_size_i), .setup_size_i(setup_size_i), .const_size_i(const_size_i),
        .total_size_i(total_size_i), .busy_o(busy_o), .geo_start_o(geo_start_o),
        .clip_start_o(clip_start_o), .setup_start_o(setup_start_o),
        .const_start_o(const_start_o), .constrained_o(constrained_o),
        .fence_pulse_o(fence_pulse_o), .fatal_o(fatal_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Strobe once, optionally poke a second strobe mid-search, count busy and pulses.
    task automatic run_recalc(input int v, input int s, input int c, input int tot,
                              input int m, input bit poke,
                              output int bcyc, output int npul);
        @(negedge clk);
        vtx_size_i = SZW'(v); setup_size_i = SZW'(s); const_size_i = SZW'(c);
        total_size_i = OFFW'(tot); mode_i = 2'(m); recalc_i = 1'b1;
        @(negedge clk);
        recalc_i = 1'b0;
        bcyc = 0; npul = 0;
        while (busy_o && bcyc < 200) begin
            bcyc++;
            if (poke && bcyc == 2) begin
                vtx_size_i = SZW'(9); recalc_i = 1'b1;
            end else begin
                vtx_size_i = SZW'(v); recalc_i = 1'b0;
            end
            @(negedge clk);
            if (fence_pulse_o) npul++;
        end
        recalc_i = 1'b0; vtx_size_i = SZW'(v);
        @(negedge clk);
        if (fence_pulse_o) npul++;
    endtask

    task automatic check_layout(input string req, input int g, input int cl, input int st,
                                input int cn, input int cons, input int fat);
        check(req, "geo_start", int'(geo_start_o), g);
        check(req, "clip_start", int'(clip_start_o), cl);
        check(req, "setup_start", int'(setup_start_o), st);
        check(req, "const_start", int'(const_start_o), cn);
        check(req, "constrained", int'(constrained_o), cons);
        check(req, "fatal", int'(fatal_o), fat);
    endtask

    task automatic t_reset();
        // R13
        check("R13", "busy", int'(busy_o), 0);
        check("R13", "pulse", int'(fence_pulse_o), 0);
        check_layout("R13", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_base_pref();
        int b, p;
        // R2 R1 R11: base tier fits at once; mid-search strobe ignored
        run_recalc(1, 1, 1, 200, 0, 1'b1, b, p);
        check("R11", "busy cycles", b, 6);
        check("R12", "pulses", p, 1);
        check_layout("R2", 32, 40, 50, 58, 0, 0);
    endtask

    task automatic t_ignored();
        int b, p;
        // R9: equal sizes, not constrained -> no effect
        run_recalc(1, 1, 1, 10, 1, 1'b0, b, p);
        check("R9", "busy cycles", b, 0);
        check("R9", "pulses", p, 0);
        check_layout("R9", 32, 40, 50, 58, 0, 0);
    endtask

    task automatic t_wide_fits();
        int b, p;
        // R3 R1: 128 vertex, 48 setup of size 2
        run_recalc(1, 2, 1, 300, 1, 1'b0, b, p);
        check("R3", "busy cycles", b, 6);
        check("R12", "pulses", p, 1);
        check_layout("R3", 128, 136, 146, 242, 0, 0);
    endtask

    task automatic t_wide_falls_back();
        int b, p;
        // R5: boost misses, preferred fits, constrained set
        run_recalc(1, 2, 2, 150, 1, 1'b0, b, p);
        check("R5", "busy cycles", b, 12);
        check("R12", "pulses", p, 1);
        check_layout("R5", 32, 40, 50, 66, 1, 0);
    endtask

    task automatic t_mid_fits();
        int b, p;
        // R4: 64 vertex entries of size 2
        run_recalc(2, 2, 2, 200, 2, 1'b0, b, p);
        check("R4", "busy cycles", b, 6);
        check("R12", "pulses", p, 1);
        check_layout("R4", 128, 144, 164, 180, 0, 0);
    endtask

    task automatic t_minimum();
        int b, p;
        // R6: preferred misses, minimum fits
        run_recalc(4, 2, 3, 120, 0, 1'b0, b, p);
        check("R6", "busy cycles", b, 12);
        check("R12", "pulses", p, 1);
        check_layout("R6", 64, 80, 100, 102, 1, 0);
    endtask

    task automatic t_shrink();
        int b, p;
        // R10: smaller vertex size while constrained re-partitions
        run_recalc(3, 2, 3, 120, 0, 1'b0, b, p);
        check("R10", "busy cycles", b, 12);
        check("R10", "pulses", p, 1);
        check_layout("R10", 48, 60, 75, 77, 1, 0);
    endtask

    task automatic t_fatal();
        int b, p;
        // R7: minimum misses -> fatal, starts kept, no pulse
        run_recalc(4, 2, 4, 100, 0, 1'b0, b, p);
        check("R7", "busy cycles", b, 12);
        check("R7", "pulses", p, 0);
        check_layout("R7", 48, 60, 75, 77, 1, 1);
    endtask

    task automatic t_clamp();
        int b, p;
        // R8: zero sizes behave as one; R7 fatal cleared on success
        run_recalc(0, 0, 0, 200, 3, 1'b0, b, p);
        check("R8", "busy cycles", b, 6);
        check("R8", "pulses", p, 1);
        check_layout("R8", 32, 40, 50, 58, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_pref();
        t_ignored();
        t_wide_fits();
        t_wide_falls_back();
        t_mid_fits();
        t_minimum();
        t_shrink();
        t_fatal();
        t_clamp();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule